// File: doc/BRIEF.md
# Scaler Phase Accumulator

This block generates sample positions for one direction of a polyphase scaler. It keeps a fixed-point position made of an integer sample index and a fraction. A line-start pulse loads that position from a programmed initial value. Each output-sample strobe then reports three things for the current sample: which input sample it sits on, which of 64 filter phases to use, and how many input samples the source must step forward before the next output sample. After reporting, the block advances the position by the scale ratio.

Luma and chroma each get their own instance. For interlaced output, a field-select input picks the bottom-field start position when a line begins. That position is the programmed initial value plus one ratio step, and it is formed inside the block. Filter arithmetic and coefficient storage sit downstream and are not part of this block.

The ratio is an unsigned value with 3 integer bits and 19 fraction bits, so 1.0 is 0x80000. The initial fraction is given as its 19 significant bits. This is the same as a 24-bit fraction field whose 5 low bits are always zero.

Top module: `scl_phase_acc`

## Requirements
- R1: After reset, smp_valid_o is low and smp_phase_o, smp_adv_o and smp_index_o are all zero.
- R2: When line_start_i is high and field_bot_i is low, the position is loaded with the initial integer and fraction. The first strobe after that reports smp_index_o equal to the initial integer and the phase taken from that fraction.
- R3: When line_start_i is high and field_bot_i is high, the position is loaded with the initial value plus cfg_ratio_i. A carry out of the fraction reaches the integer index.
- R4: Each strobe adds cfg_ratio_i to the position. smp_adv_o is the increase of the integer index caused by that addition, a value from 0 to 8.
- R5: smp_phase_o is fraction bits [18:13] of the position being reported, which are the top 6 bits of the 24-bit fraction field. It is forced to 0 when cfg_taps_m1_i (tap count minus one, 0 to 7) is 0.
- R6: Outputs are registered. smp_valid_o is high in exactly the cycle after a strobe that is accepted. In any cycle with smp_valid_o low, the other outputs keep their previous values.
- R7: line_start_i has priority. A step_i in the same cycle is ignored: no output is produced and the position is the freshly loaded one.
- R8: bypass_o is high exactly when cfg_ratio_i equals 1.0 (0x80000).
- R9: The integer index wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ratio_i | input | 22 | Scale ratio, unsigned 3.19 |
| cfg_init_int_i | input | 16 | Initial position, integer part |
| cfg_init_frac_i | input | 19 | Initial position, significant fraction bits |
| cfg_taps_m1_i | input | 3 | Filter tap count minus one |
| line_start_i | input | 1 | Load the initial position |
| field_bot_i | input | 1 | Select the bottom-field start on load |
| step_i | input | 1 | Output-sample strobe |
| smp_valid_o | output | 1 | Sample report valid |
| smp_phase_o | output | 6 | Filter phase index |
| smp_adv_o | output | 4 | Input samples to advance |
| smp_index_o | output | 16 | Input sample index of this sample |
| bypass_o | output | 1 | Ratio is exactly 1.0 |

## Verification
A line-start pulse has no visible result of its own. Its effect shows up on the report produced by the following strobe. Every sample report, which covers phase, index, advance and valid, appears one clock after the edge that accepts its strobe. bypass_o is combinational and follows the ratio input within the same cycle. The bench drives inputs on falling edges and checks each report on the next falling edge, which is half a cycle after the register loads. It also checks that the report stays unchanged through the idle cycles that follow.

// File: rtl/scl_pa_pkg.sv
package scl_pa_pkg;

    localparam int FRAC_BITS      = 19;
    localparam int RATIO_INT_BITS = 3;
    localparam int INDEX_BITS     = 16;
    localparam int PHASE_BITS     = 6;
    localparam int TAP_BITS       = 3;

    // Fraction bits implied as zero below the stored ones in the 24-bit field.
    localparam int FIELD_FRAC_BITS = 24;
    localparam int IMPLIED_ZERO    = FIELD_FRAC_BITS - FRAC_BITS;

endpackage

// File: rtl/scl_pa_load.sv
module scl_pa_load #(
    parameter int FRAC_W  = 19,
    parameter int RATIO_W = 22,
    parameter int INDEX_W = 16
) (
    input  logic [INDEX_W-1:0] init_int_i,
    input  logic [FRAC_W-1:0]  init_frac_i,
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               bottom_i,
    output logic [INDEX_W-1:0] load_int_o,
    output logic [FRAC_W-1:0]  load_frac_o
);
    localparam int POS_W = INDEX_W + FRAC_W;

    logic [POS_W-1:0] top_pos;
    logic [POS_W-1:0] bot_pos;

    always_comb begin
        top_pos = {init_int_i, init_frac_i};
        bot_pos = top_pos + POS_W'(ratio_i);
    end

    assign load_int_o  = bottom_i ? bot_pos[POS_W-1:FRAC_W] : init_int_i;
    assign load_frac_o = bottom_i ? bot_pos[FRAC_W-1:0]     : init_frac_i;
endmodule

// File: rtl/scl_pa_advance.sv
module scl_pa_advance #(
    parameter int FRAC_W  = 19,
    parameter int RATIO_W = 22,
    parameter int INDEX_W = 16,
    parameter int ADV_W   = 4
) (
    input  logic [INDEX_W-1:0] pos_int_i,
    input  logic [FRAC_W-1:0]  pos_frac_i,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [INDEX_W-1:0] nxt_int_o,
    output logic [FRAC_W-1:0]  nxt_frac_o,
    output logic [ADV_W-1:0]   adv_o
);
    localparam int RINT_W = RATIO_W - FRAC_W;

    logic [FRAC_W:0]       frac_sum;
    logic [RINT_W-1:0]     ratio_int;
    logic [ADV_W-1:0]      adv;

    always_comb begin
        frac_sum  = {1'b0, pos_frac_i} + {1'b0, ratio_i[FRAC_W-1:0]};
        ratio_int = ratio_i[RATIO_W-1:FRAC_W];
        adv       = ADV_W'(ratio_int) + ADV_W'(frac_sum[FRAC_W]);
    end

    assign adv_o      = adv;
    assign nxt_frac_o = frac_sum[FRAC_W-1:0];
    assign nxt_int_o  = pos_int_i + INDEX_W'(adv);
endmodule

// File: rtl/scl_pa_phase.sv
module scl_pa_phase #(
    parameter int FRAC_W  = 19,
    parameter int PHASE_W = 6,
    parameter int TAP_W   = 3
) (
    input  logic [FRAC_W-1:0]  frac_i,
    input  logic [TAP_W-1:0]   taps_m1_i,
    output logic [PHASE_W-1:0] phase_o
);
    logic [PHASE_W-1:0] raw_phase;

    generate
        if (FRAC_W >= PHASE_W) begin : g_slice
            assign raw_phase = frac_i[FRAC_W-1 -: PHASE_W];
        end else begin : g_pad
            assign raw_phase = {frac_i, {(PHASE_W-FRAC_W){1'b0}}};
        end
    endgenerate

    // A single tap has no phase choice.
    assign phase_o = (taps_m1_i == '0) ? '0 : raw_phase;
endmodule

// File: rtl/scl_phase_acc.sv
module scl_phase_acc
    import scl_pa_pkg::*;
#(
    parameter int FRAC_W  = FRAC_BITS,
    parameter int RINT_W  = RATIO_INT_BITS,
    parameter int INDEX_W = INDEX_BITS,
    parameter int PHASE_W = PHASE_BITS,
    parameter int TAP_W   = TAP_BITS,
    localparam int RATIO_W = RINT_W + FRAC_W,
    localparam int ADV_W   = RINT_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] cfg_ratio_i,
    input  logic [INDEX_W-1:0] cfg_init_int_i,
    input  logic [FRAC_W-1:0]  cfg_init_frac_i,
    input  logic [TAP_W-1:0]   cfg_taps_m1_i,
    input  logic               line_start_i,
    input  logic               field_bot_i,
    input  logic               step_i,
    output logic               smp_valid_o,
    output logic [PHASE_W-1:0] smp_phase_o,
    output logic [ADV_W-1:0]   smp_adv_o,
    output logic [INDEX_W-1:0] smp_index_o,
    output logic               bypass_o
);
    localparam logic [RATIO_W-1:0] RATIO_ONE = RATIO_W'(1) << FRAC_W;

    typedef struct packed {
        logic [INDEX_W-1:0] pos_int;
        logic [FRAC_W-1:0]  pos_frac;
        logic               valid;
        logic [PHASE_W-1:0] phase;
        logic [ADV_W-1:0]   adv;
        logic [INDEX_W-1:0] index;
    } acc_state_t;

    acc_state_t st_d, st_q;

    logic [INDEX_W-1:0] load_int;
    logic [FRAC_W-1:0]  load_frac;
    logic [INDEX_W-1:0] nxt_int;
    logic [FRAC_W-1:0]  nxt_frac;
    logic [ADV_W-1:0]   step_adv;
    logic [PHASE_W-1:0] cur_phase;

    scl_pa_load #(
        .FRAC_W(FRAC_W), .RATIO_W(RATIO_W), .INDEX_W(INDEX_W)
    ) i_load (
        .init_int_i  (cfg_init_int_i),
        .init_frac_i (cfg_init_frac_i),
        .ratio_i     (cfg_ratio_i),
        .bottom_i    (field_bot_i),
        .load_int_o  (load_int),
        .load_frac_o (load_frac)
    );

    scl_pa_advance #(
        .FRAC_W(FRAC_W), .RATIO_W(RATIO_W), .INDEX_W(INDEX_W), .ADV_W(ADV_W)
    ) i_adv (
        .pos_int_i  (st_q.pos_int),
        .pos_frac_i (st_q.pos_frac),
        .ratio_i    (cfg_ratio_i),
        .nxt_int_o  (nxt_int),
        .nxt_frac_o (nxt_frac),
        .adv_o      (step_adv)
    );

    scl_pa_phase #(
        .FRAC_W(FRAC_W), .PHASE_W(PHASE_W), .TAP_W(TAP_W)
    ) i_phase (
        .frac_i    (st_q.pos_frac),
        .taps_m1_i (cfg_taps_m1_i),
        .phase_o   (cur_phase)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (line_start_i) begin
            st_d.pos_int  = load_int;
            st_d.pos_frac = load_frac;
        end else if (step_i) begin
            st_d.valid    = 1'b1;
            st_d.phase    = cur_phase;
            st_d.index    = st_q.pos_int;
            st_d.adv      = step_adv;
            st_d.pos_int  = nxt_int;
            st_d.pos_frac = nxt_frac;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign smp_valid_o = st_q.valid;
    assign smp_phase_o = st_q.phase;
    assign smp_adv_o   = st_q.adv;
    assign smp_index_o = st_q.index;
    assign bypass_o    = (cfg_ratio_i == RATIO_ONE);
endmodule

// File: rtl/scl_phase_acc_chk.sv
module scl_phase_acc_chk #(
    parameter int PHASE_W = 6,
    parameter int ADV_W   = 4,
    parameter int INDEX_W = 16,
    parameter int TAP_W   = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_start_i,
    input logic               step_i,
    input logic [TAP_W-1:0]   cfg_taps_m1_i,
    input logic               smp_valid_o,
    input logic [PHASE_W-1:0] smp_phase_o,
    input logic [ADV_W-1:0]   smp_adv_o,
    input logic [INDEX_W-1:0] smp_index_o
);
    localparam int ADV_MAX = 1 << (ADV_W - 1);

    // R6
    valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !line_start_i) |=> smp_valid_o);

    // R6
    idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_i && !line_start_i) |=> !smp_valid_o);

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid_o |-> ($stable(smp_phase_o) && $stable(smp_adv_o) && $stable(smp_index_o)));

    // R7
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && step_i) |=> !smp_valid_o);

    // R5
    single_tap_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !line_start_i && cfg_taps_m1_i == '0) |=> (smp_phase_o == '0));

    // R4
    adv_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid_o |-> (int'(smp_adv_o) <= ADV_MAX));
endmodule

bind scl_phase_acc scl_phase_acc_chk #(
    .PHASE_W(PHASE_W), .ADV_W(ADV_W), .INDEX_W(INDEX_W), .TAP_W(TAP_W)
) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .line_start_i  (line_start_i),
    .step_i        (step_i),
    .cfg_taps_m1_i (cfg_taps_m1_i),
    .smp_valid_o   (smp_valid_o),
    .smp_phase_o   (smp_phase_o),
    .smp_adv_o     (smp_adv_o),
    .smp_index_o   (smp_index_o)
);

// File: tb/test_scl_phase_acc.sv
`timescale 1ns/1ps
module test_scl_phase_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [21:0] cfg_ratio = '0;
    logic [15:0] cfg_init_int = '0;
    logic [18:0] cfg_init_frac = '0;
    logic [2:0]  cfg_taps_m1 = '0;
    logic        line_start = 1'b0;
    logic        field_bot = 1'b0;
    logic        step = 1'b0;
    logic        smp_valid;
    logic [5:0]  smp_phase;
    logic [3:0]  smp_adv;
    logic [15:0] smp_index;
    logic        bypass;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    scl_phase_acc i_scl_phase_acc (
        .clk(clk), .rst_n(rst_n),
        .cfg_ratio_i(cfg_ratio), .cfg_init_int_i(cfg_init_int),
        .cfg_init_frac_i(cfg_init_frac), .cfg_taps_m1_i(cfg_taps_m1),
        .line_start_i(line_start), .field_bot_i(field_bot), .step_i(step),
        .smp_valid_o(smp_valid), .smp_phase_o(smp_phase), .smp_adv_o(smp_adv),
        .smp_index_o(smp_index), .bypass_o(bypass)
    );

    typedef struct packed {
        logic [21:0] ratio;
        logic [15:0] iint;
        logic [18:0] ifrac;
        logic        bot;
        logic [2:0]  taps;
        logic [7:0]  n;
        logic [5:0]  ph0;
        logic [15:0] idx0;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{22'h080000, 16'h0000, 19'h00000, 1'b0, 3'd3, 8'd4, 6'd0,  16'h0000},
        '{22'h040000, 16'h0000, 19'h20000, 1'b0, 3'd3, 8'd5, 6'd16, 16'h0000},
        '{22'h140000, 16'h0003, 19'h00000, 1'b1, 3'd3, 8'd4, 6'd32, 16'h0005},
        '{22'h3FFFFF, 16'h0000, 19'h7FFFF, 1'b0, 3'd7, 8'd3, 6'd63, 16'h0000},
        '{22'h060000, 16'h0000, 19'h40000, 1'b0, 3'd0, 8'd4, 6'd0,  16'h0000},
        '{22'h060000, 16'h0000, 19'h40000, 1'b1, 3'd5, 8'd4, 6'd16, 16'h0001},
        '{22'h080000, 16'hFFFF, 19'h00000, 1'b0, 3'd1, 8'd3, 6'd0,  16'hFFFF}
    };

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R2 R3 R4 R5 R9: walk one vector with a bench-side position model
    task automatic run_vec(input vec_t v);
        longint pos, nxt;
        @(negedge clk);
        cfg_ratio = v.ratio; cfg_init_int = v.iint; cfg_init_frac = v.ifrac;
        cfg_taps_m1 = v.taps; field_bot = v.bot; line_start = 1'b1; step = 1'b0;
        pos = (longint'(v.iint) << 19) | longint'(v.ifrac);
        if (v.bot) pos = (pos + longint'(v.ratio)) & ((64'd1 << 35) - 1);
        @(negedge clk);
        line_start = 1'b0; step = 1'b1;
        for (int i = 0; i < int'(v.n); i++) begin
            @(negedge clk);
            if (i == int'(v.n) - 1) step = 1'b0;
            nxt = pos + longint'(v.ratio);
            chk("R6", "valid", smp_valid, 1);
            chk("R5", "phase", smp_phase, (v.taps == 0) ? 0 : ((pos >> 13) & 63));
            chk("R9", "index", smp_index, (pos >> 19) & 16'hFFFF);
            chk("R4", "adv", smp_adv, (nxt >> 19) - (pos >> 19));
            if (i == 0) begin
                chk(v.bot ? "R3" : "R2", "first phase", smp_phase, v.ph0);
                chk(v.bot ? "R3" : "R2", "first index", smp_index, v.idx0);
            end
            pos = nxt & ((64'd1 << 35) - 1);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid", smp_valid, 0);
        chk("R1", "phase", smp_phase, 0);
        chk("R1", "adv", smp_adv, 0);
        chk("R1", "index", smp_index, 0);

        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R6: idle cycles keep the last report
        @(negedge clk);
        chk("R6", "idle valid", smp_valid, 0);
        chk("R6", "held index", smp_index, 16'h0001);
        @(negedge clk);
        chk("R6", "held phase", smp_phase, 0);

        // R7: load and step together, step ignored
        cfg_ratio = 22'h0A0000; cfg_init_int = 16'h0010; cfg_init_frac = 19'h60000;
        cfg_taps_m1 = 3'd3; field_bot = 1'b0; line_start = 1'b1; step = 1'b1;
        @(negedge clk);
        chk("R7", "no valid", smp_valid, 0);
        line_start = 1'b0; step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        chk("R7", "index after load", smp_index, 16'h0010);
        chk("R7", "phase after load", smp_phase, 48);
        chk("R4", "adv 1.25 from .75", smp_adv, 2);

        // R8
        cfg_ratio = 22'h080000; #1;
        chk("R8", "bypass at 1.0", bypass, 1);
        cfg_ratio = 22'h080001; #1;
        chk("R8", "bypass off", bypass, 0);
        cfg_ratio = 22'h040000; #1;
        chk("R8", "bypass off 0.5", bypass, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule